// File: doc/BRIEF.md
# Split-Bank Memory Access Sequencer

This block connects a processor core to a 16-bit data bus whose memory is built from two byte-wide banks. The lower bank holds the even byte addresses and the upper bank holds the odd ones. The core hands over one request at a time. A request carries a 20-bit byte address, a size (byte or word), a direction and 16 bits of write data. The sequencer then runs the bus cycles the request needs and reports completion with a one-cycle pulse. For a read, the assembled 16-bit result comes with that pulse.

Bank selection uses two signals. Bit 0 of the bus address selects the lower bank when it is 0. An active-low upper-enable strobe selects the upper bank when it is 0. Three cases finish in one bus cycle: a byte at either parity, and a word at an even address. A word at an odd address straddles two bank rows, so it becomes two byte cycles. The first cycle uses the odd address on the upper lanes. The second uses the following address on the lower lanes. The sequencer swaps the bytes so that the core always sees the lower-addressed byte in bits 7:0.

A bus cycle lasts from the cycle in which `busStrobe` rises until the clock edge at which `busReady` is sampled high. While the cycle waits, the address, the enable and the write lanes hold still.

Top module: `split_bank_seq`

## Requirements
- R1: A byte access at an even address runs one bus cycle with busAddr equal to the request address (bit 0 = 0) and busHighEnN = 1. A read returns busRdata[7:0] in doneRdata[7:0], with doneRdata[15:8] = 0.
- R2: A byte access at an odd address runs one bus cycle with busAddr equal to the request address (bit 0 = 1) and busHighEnN = 0. A read returns busRdata[15:8] in doneRdata[7:0], with doneRdata[15:8] = 0.
- R3: A word access at an even address runs exactly one bus cycle with bit 0 = 0 and busHighEnN = 0, and a read returns busRdata unchanged. The following odd address never appears on busAddr.
- R4: A word access at an odd address runs exactly two bus cycles. The first drives the request address with busHighEnN = 0. The second drives the request address plus one (bit 0 = 0) with busHighEnN = 1. In every bus cycle at least one bank is enabled.
- R5: For a word read at an odd address, busRdata[15:8] of the first cycle lands in doneRdata[7:0], and busRdata[7:0] of the second cycle lands in doneRdata[15:8].
- R6: A write drives busWrite = 1 during each of its bus cycles, and the lane that is not enabled carries zero. An even byte goes out on busWdata[7:0] and an odd byte on busWdata[15:8]. An aligned word goes out as reqWdata. An odd word sends reqWdata[7:0] on busWdata[15:8] in the first cycle and reqWdata[15:8] on busWdata[7:0] in the second.
- R7: reqReady is 1 only while idle, and a request is taken when reqValid and reqReady are both 1. reqValid and the request fields have no effect while a request is in progress.
- R8: doneValid is a single-cycle pulse, once per request, in the cycle after the edge at which the final bus cycle saw busReady. doneRdata is valid with it.
- R9: The second cycle of an odd word at address 0xFFFFF drives address 0x00000 (the increment wraps modulo 2^20).
- R10: busStrobe is 0 while idle. While a bus cycle waits for busReady, busAddr and busHighEnN stay stable.
- R11: After reset the block is idle: reqReady = 1, busStrobe = 0, doneValid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Core presents a request |
| reqReady | output | 1 | Block is idle and takes a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = 16-bit word, 0 = byte |
| reqAddr | input | 20 | Starting byte address |
| reqWdata | input | 16 | Write data; a byte uses bits 7:0 |
| doneValid | output | 1 | One-cycle completion pulse |
| doneRdata | output | 16 | Assembled read result |
| busStrobe | output | 1 | A bus cycle is in progress |
| busWrite | output | 1 | The current bus cycle is a write |
| busAddr | output | 20 | Bus byte address; bit 0 is the lower-bank select (active low) |
| busHighEnN | output | 1 | Upper-bank enable, active low |
| busWdata | output | 16 | Write lanes: bits 7:0 lower bank, bits 15:8 upper bank |
| busRdata | input | 16 | Read lanes, same lane split |
| busReady | input | 1 | The bus cycle completes at this edge |

## Verification
The bench's bus model always drives both read lanes with distinct bytes that depend on the address. A design that read the wrong lane, skipped the zero extension, or left the misaligned halves in their lane order would return a visibly wrong result. Odd words run with wait states and are checked for the exact cycle count, the second-cycle address and enable, and the address wrap at the top of memory. A design that reused the first address, incremented without the wrap, or merged the split into one cycle would fail those checks. A request held on reqValid while the block is busy must not start extra bus cycles or replace the latched address. The done pulse must follow the final ready exactly once.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef struct packed {
    logic loadReq;
    logic busActive;
    logic secondPhase;
    logic captureFirst;
    logic captureSecond;
  } ctrlStrobes_t;
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         busReady,
  input  logic         splitWord,
  output logic         reqReady,
  output logic         doneValid,
  output ctrlStrobes_t ctrl
);
  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND, ST_DONE} seqState_t;
  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_FIRST;
      ST_FIRST:  if (busReady) stateNext = splitWord ? ST_SECOND : ST_DONE;
      ST_SECOND: if (busReady) stateNext = ST_DONE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    reqReady           = (state == ST_IDLE);
    doneValid          = (state == ST_DONE);
    ctrl.loadReq       = reqReady && reqValid;
    ctrl.busActive     = (state == ST_FIRST) || (state == ST_SECOND);
    ctrl.secondPhase   = (state == ST_SECOND);
    ctrl.captureFirst  = (state == ST_FIRST) && busReady;
    ctrl.captureSecond = (state == ST_SECOND) && busReady;
  end

  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> $past(ctrl.busActive && busReady)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid); // R8
  AST_ACCEPT_STARTS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.loadReq |=> ctrl.busActive && !ctrl.secondPhase); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.busActive |-> !reqReady); // R7
endmodule

// File: rtl/sbs_datapath.sv
module sbs_datapath
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      ctrl,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic              splitWord,
  output logic [DATA_W-1:0] resultData,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busHighEnN,
  output logic [DATA_W-1:0] busWdata
);
  localparam int BYTE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              wordQ;
  logic              writeQ;
  logic [ADDR_W-1:0] addrNext;
  logic [BYTE_W-1:0] lowLane;
  logic [BYTE_W-1:0] highLane;

  assign lowLane   = busRdata[BYTE_W-1:0];
  assign highLane  = busRdata[DATA_W-1:BYTE_W];
  assign addrNext  = addrQ + ADDR_W'(1);
  assign splitWord = wordQ && addrQ[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ      <= '0;
      wdataQ     <= '0;
      wordQ      <= 1'b0;
      writeQ     <= 1'b0;
      resultData <= '0;
    end else begin
      if (ctrl.loadReq) begin
        addrQ      <= reqAddr;
        wdataQ     <= reqWdata;
        wordQ      <= reqWord;
        writeQ     <= reqWrite;
        resultData <= '0;
      end
      if (ctrl.captureFirst) begin
        if (!wordQ)
          resultData <= {{BYTE_W{1'b0}}, (addrQ[0] ? highLane : lowLane)};
        else if (!addrQ[0])
          resultData <= busRdata;
        else
          resultData[BYTE_W-1:0] <= highLane;
      end
      if (ctrl.captureSecond)
        resultData[DATA_W-1:BYTE_W] <= lowLane;
    end
  end

  always_comb begin
    busWrite = writeQ && ctrl.busActive;
    if (ctrl.secondPhase) begin
      busAddr    = addrNext;
      busHighEnN = 1'b1;
      busWdata   = {{BYTE_W{1'b0}}, wdataQ[DATA_W-1:BYTE_W]};
    end else begin
      busAddr    = addrQ;
      busHighEnN = !(wordQ || addrQ[0]);
      if (wordQ && !addrQ[0])
        busWdata = wdataQ;
      else if (addrQ[0])
        busWdata = {wdataQ[BYTE_W-1:0], {BYTE_W{1'b0}}};
      else
        busWdata = {{BYTE_W{1'b0}}, wdataQ[BYTE_W-1:0]};
    end
  end

  AST_BANK_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.busActive |-> !(busAddr[0] && busHighEnN)); // R4
  AST_SECOND_LOWER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.busActive && ctrl.secondPhase) |-> (!busAddr[0] && busHighEnN)); // R4
  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.busActive && !busReady) |=> ($stable(busAddr) && $stable(busHighEnN))); // R10
endmodule

// File: rtl/split_bank_seq.sv
module split_bank_seq
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRdata,
  output logic              busStrobe,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busHighEnN,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady
);
  ctrlStrobes_t ctrl;
  logic         splitWord;

  sbs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .busReady  (busReady),
    .splitWord (splitWord),
    .reqReady  (reqReady),
    .doneValid (doneValid),
    .ctrl      (ctrl)
  );

  sbs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .reqWrite   (reqWrite),
    .reqWord    (reqWord),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .busRdata   (busRdata),
    .busReady   (busReady),
    .splitWord  (splitWord),
    .resultData (doneRdata),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .busHighEnN (busHighEnN),
    .busWdata   (busWdata)
  );

  assign busStrobe = ctrl.busActive;

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> !busStrobe); // R10
endmodule

// File: tb/split_bank_seq_test.sv
`timescale 1ns/1ps
module split_bank_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        reqReady, doneValid, busStrobe, busWrite, busHighEnN;
  logic [15:0] doneRdata, busWdata;
  logic [19:0] busAddr;
  logic [15:0] busRdata = '0;
  logic        busReady = 1'b0;

  always #4 clk = ~clk;

  split_bank_seq uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .doneValid(doneValid), .doneRdata(doneRdata), .busStrobe(busStrobe),
    .busWrite(busWrite), .busAddr(busAddr), .busHighEnN(busHighEnN),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'hA5;
  endfunction

  // bus model and monitor, all on the falling edge
  int          waitTarget = 0, waitCnt = 0, logCount = 0, donePulses = 0;
  bit          holding = 0;
  logic [19:0] holdAddr;
  logic [19:0] logAddr [8];
  logic        logHen  [8];
  logic        logWr   [8];
  logic [15:0] logWd   [8];

  always @(negedge clk) begin
    if (rst_n) begin
      if (doneValid) begin
        donePulses++;
        check("R8", "ready seen before done", busReady, 1);
      end
      if (reqReady && busStrobe) check("R10", "strobe while idle", 1, 0);
    end
    if (busReady) begin
      busReady = 1'b0;
      waitCnt  = 0;
      holding  = 0;
    end else if (busStrobe) begin
      if (!holding) begin
        holding  = 1;
        holdAddr = busAddr;
      end else check("R10", "address held while waiting", busAddr, holdAddr);
      if (waitCnt >= waitTarget) begin
        busReady = 1'b1;
        busRdata = {memByte({busAddr[19:1], 1'b1}), memByte({busAddr[19:1], 1'b0})};
        if (logCount < 8) begin
          logAddr[logCount] = busAddr;
          logHen[logCount]  = busHighEnN;
          logWr[logCount]   = busWrite;
          logWd[logCount]   = busWdata;
        end
        logCount++;
      end else waitCnt++;
    end
  end

  task automatic runOp(bit wr, bit wd, logic [19:0] a, logic [15:0] d, int waits,
                       output logic [15:0] rd);
    int cyc;
    @(negedge clk);
    waitTarget = waits; logCount = 0; donePulses = 0;
    reqValid = 1'b1; reqWrite = wr; reqWord = wd; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0;
    while (!doneValid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    rd = doneRdata;
    @(negedge clk);
  endtask

  task automatic verifyOp(bit wr, bit wd, logic [19:0] a, logic [15:0] d, int waits, int expCyc);
    logic [15:0] rd, expRd;
    logic [19:0] a1;
    string tag;
    tag = wd ? (a[0] ? "R4" : "R3") : (a[0] ? "R2" : "R1");
    a1  = a + 20'd1;
    runOp(wr, wd, a, d, waits, rd);
    check("R8", "done pulses per request", donePulses, 1);
    check(tag, "bus cycle count", logCount, expCyc);
    check(tag, "first address", logAddr[0], a);
    check(tag, "first upper enable", logHen[0], !(wd || a[0]));
    check(wr ? "R6" : tag, "busWrite", logWr[0], wr);
    if (expCyc == 2) begin
      check((a == 20'hFFFFF) ? "R9" : "R4", "second address", logAddr[1], a1);
      check("R4", "second upper enable", logHen[1], 1);
    end
    if (wr) begin
      if (wd && a[0]) begin
        check("R6", "odd word first lanes", logWd[0], {d[7:0], 8'h00});
        check("R6", "odd word second lanes", logWd[1], {8'h00, d[15:8]});
      end else if (wd) check("R6", "aligned word lanes", logWd[0], d);
      else if (a[0])   check("R6", "odd byte lanes", logWd[0], {d[7:0], 8'h00});
      else             check("R6", "even byte lanes", logWd[0], {8'h00, d[7:0]});
    end else begin
      expRd = wd ? {memByte(a1), memByte(a)} : {8'h00, memByte(a)};
      check((wd && a[0]) ? "R5" : tag, "read result", rd, expRd);
    end
  endtask

  // {write, word, addr[19:0], wdata[15:0], waits[1:0], busCycles[1:0]}
  localparam logic [41:0] VEC [10] = '{
    {1'b0, 1'b0, 20'h00004, 16'h0000, 2'd0, 2'd1},
    {1'b0, 1'b1, 20'h00004, 16'h0000, 2'd1, 2'd1},
    {1'b0, 1'b0, 20'h00005, 16'h0000, 2'd0, 2'd1},
    {1'b0, 1'b1, 20'h00005, 16'h0000, 2'd2, 2'd2},
    {1'b1, 1'b0, 20'h00010, 16'h1234, 2'd0, 2'd1},
    {1'b1, 1'b0, 20'h00011, 16'hABCD, 2'd1, 2'd1},
    {1'b1, 1'b1, 20'h00020, 16'hBEEF, 2'd0, 2'd1},
    {1'b1, 1'b1, 20'h00021, 16'hCAFE, 2'd3, 2'd2},
    {1'b0, 1'b1, 20'h7A3C9, 16'h0000, 2'd0, 2'd2},
    {1'b0, 1'b0, 20'hFFFFF, 16'h0000, 2'd1, 2'd1}
  };

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    check("R11", "reqReady in reset", reqReady, 1);
    check("R11", "busStrobe in reset", busStrobe, 0);
    check("R11", "doneValid in reset", doneValid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "idle after reset", {reqReady, busStrobe, doneValid}, 3'b100);

    for (int i = 0; i < 10; i++)
      verifyOp(VEC[i][41], VEC[i][40], VEC[i][39:20], VEC[i][19:4],
               int'(VEC[i][3:2]), int'(VEC[i][1:0]));

    // R9: odd word at the top of memory wraps to address zero
    verifyOp(1'b0, 1'b1, 20'hFFFFF, 16'h0000, 1, 2);
    verifyOp(1'b1, 1'b1, 20'hFFFFF, 16'h5AC3, 0, 2);

    // R7: a second request held on reqValid while busy is ignored
    @(negedge clk);
    waitTarget = 3; logCount = 0; donePulses = 0;
    reqValid = 1'b1; reqWrite = 1'b0; reqWord = 1'b0; reqAddr = 20'h00040; reqWdata = '0;
    @(negedge clk);
    reqWrite = 1'b1; reqWord = 1'b1; reqAddr = 20'h00091; reqWdata = 16'hFFFF;
    check("R7", "reqReady low while busy", reqReady, 0);
    for (int k = 0; k < 100 && !doneValid; k++) @(negedge clk);
    reqValid = 1'b0;
    rd = doneRdata;
    check("R7", "bus cycles with request held", logCount, 1);
    check("R7", "latched address kept", logAddr[0], 20'h00040);
    check("R7", "latched direction kept", logWr[0], 0);
    check("R1", "byte read under held request", rd, {8'h00, memByte(20'h00040)});
    @(negedge clk);
    check("R7", "reqReady back when idle", reqReady, 1);
    check("R8", "single done pulse", donePulses, 1);
    repeat (2) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule